// File: doc/BRIEF.md
# Unsigned Add/Subtract Unit with Magnitude Correction

This block is a purely combinational arithmetic unit for two unsigned operands of `WIDTH` bits (default 4). One mode bit selects the operation. In add mode the result is the wrapped sum and the carry flag marks an unsigned overflow. In subtract mode the result is always the absolute difference, and a negative flag shows that the subtrahend was the larger operand.

Internally, a row of XOR gates inverts the second operand under control of the mode bit, and the same bit feeds the carry into the least significant bit of a ripple-carry adder. When a subtraction produces no end carry, the raw result is passed through an invert-and-increment stage that recovers the magnitude. An output multiplexer then picks either the plain sum or the corrected magnitude. The carry and signed-overflow flags always describe the raw adder stage, before any correction.

Top module: `addsub_mag`

## Requirements
- R1: With `sub_i`=0, `res_o` equals (a_i + b_i) mod 2^WIDTH and `carry_o` equals bit WIDTH of the full sum.
- R2: With `sub_i`=1 and a_i >= b_i, `res_o` equals a_i - b_i, `carry_o` is 1 and `neg_o` is 0.
- R3: With `sub_i`=1 and a_i < b_i, `res_o` equals b_i - a_i, `carry_o` is 0 and `neg_o` is 1.
- R4: `ovf_o` is 1 exactly when the raw result, read as two's complement, differs from the true signed sum (add) or signed difference a_i - b_i (subtract) of the operands read as two's complement.
- R5: With `sub_i`=0, `neg_o` is 0 for every operand pair.
- R6: Whenever `res_o` is zero, `neg_o` is 0 (equal operands in subtract mode give zero, carry 1, not negative).
- R7: The behaviour scales with `WIDTH`; at WIDTH=5, 19 - 30 gives `res_o`=11, `neg_o`=1, `carry_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend in subtract mode) |
| b_i | input | WIDTH | Second operand (subtrahend in subtract mode) |
| sub_i | input | 1 | 0 = add, 1 = subtract with magnitude output |
| res_o | output | WIDTH | Sum, or absolute difference |
| carry_o | output | 1 | Carry out of the MSB of the raw adder stage |
| neg_o | output | 1 | Subtract mode only: b_i was larger than a_i |
| ovf_o | output | 1 | Signed two's-complement overflow of the raw result |

## Verification
Every output is a pure function of the present inputs, so each result is due in the same cycle as its stimulus, with no register on the path. The bench changes inputs on the falling clock edge and samples a quarter period later, well after the combinational logic has settled and away from any edge. Expected values are recomputed from integer arithmetic for every operand pair in both modes, alongside a small vector table and a directed 5-bit case.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } addsub_op_e;
endpackage

// File: rtl/addsub_xor_row.sv
module addsub_xor_row #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] d_i,
  input  logic             inv_i,
  output logic [WIDTH-1:0] q_o
);
  // one programmable inverter per bit
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign q_o[i] = d_i[i] ^ inv_i;
  end
endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             ci_i,
  output logic [WIDTH-1:0] s_o,
  output logic             co_o,
  output logic             c_msb_o
);
  logic [WIDTH:0] c;
  assign c[0] = ci_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_fa
    assign s_o[i]   = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end

  assign co_o    = c[WIDTH];
  assign c_msb_o = c[WIDTH-1];

  always_comb begin
    a_r1_sum_word: assert ({co_o, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, ci_i}))
      else $error("ripple sum mismatch");
  end
endmodule

// File: rtl/addsub_negate.sv
module addsub_negate #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  output logic [WIDTH-1:0] y_o
);
  // invert, then increment through a half-adder chain
  logic [WIDTH-1:0] inv;
  logic [WIDTH:0]   c;
  assign inv  = ~x_i;
  assign c[0] = 1'b1;

  for (genvar i = 0; i < WIDTH; i++) begin : g_ha
    assign y_o[i]   = inv[i] ^ c[i];
    assign c[i+1]   = inv[i] & c[i];
  end

  always_comb begin
    a_r3_negate_sum: assert (WIDTH'(x_i + y_o) == '0)
      else $error("negate stage does not cancel its input");
  end
endmodule

// File: rtl/addsub_mag.sv
module addsub_mag
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o,
  output logic             neg_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  addsub_op_e       op;
  logic [WIDTH-1:0] b_x;
  logic [WIDTH-1:0] raw;
  logic [WIDTH-1:0] mag;
  logic             c_out;
  logic             c_msb;
  logic             borrow;

  assign op = addsub_op_e'(sub_i);

  addsub_xor_row #(.WIDTH(WIDTH)) i_xor_row (
    .d_i   (b_i),
    .inv_i (sub_i),
    .q_o   (b_x)
  );

  addsub_ripple #(.WIDTH(WIDTH)) i_ripple (
    .a_i     (a_i),
    .b_i     (b_x),
    .ci_i    (sub_i),
    .s_o     (raw),
    .co_o    (c_out),
    .c_msb_o (c_msb)
  );

  addsub_negate #(.WIDTH(WIDTH)) i_negate (
    .x_i (raw),
    .y_o (mag)
  );

  // no end carry in subtract mode: subtrahend was larger
  assign borrow  = (op == OP_SUB) && !c_out;
  assign res_o   = borrow ? mag : raw;
  assign carry_o = c_out;
  assign neg_o   = borrow && (res_o != '0);
  assign ovf_o   = c_out ^ c_msb;

  always_comb begin
    if (op == OP_ADD) begin
      a_r5_no_neg_in_add: assert (!neg_o) else $error("negative flag in add mode");
    end
    if (res_o == '0) begin
      a_r6_zero_not_neg: assert (!neg_o) else $error("zero result flagged negative");
    end
    if (op == OP_SUB && !neg_o) begin
      a_r2_no_borrow: assert (carry_o && res_o == WIDTH'(a_i - b_i))
        else $error("non-negative difference wrong");
    end
    a_r4_signed_ovf: assert (ovf_o == ((a_i[MSB] == b_x[MSB]) && (raw[MSB] != a_i[MSB])))
      else $error("signed overflow flag wrong");
  end
endmodule

// File: tb/test_addsub_mag.sv
module test_addsub_mag;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [W-1:0] a, b, res;
  logic sub, c, n, v;
  logic [4:0] a5, b5, res5;
  logic sub5, c5, n5, v5;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  addsub_mag #(.WIDTH(W)) i_addsub_mag (
    .a_i(a), .b_i(b), .sub_i(sub),
    .res_o(res), .carry_o(c), .neg_o(n), .ovf_o(v)
  );

  addsub_mag #(.WIDTH(5)) i_addsub_mag_w5 (
    .a_i(a5), .b_i(b5), .sub_i(sub5),
    .res_o(res5), .carry_o(c5), .neg_o(n5), .ovf_o(v5)
  );

  // {a, b, sub, res, carry, neg, ovf}
  localparam logic [15:0] VEC [9] = '{
    {4'd3,  4'd4,  1'b0, 4'd7,  3'b000},
    {4'd9,  4'd9,  1'b0, 4'd2,  3'b101},
    {4'd5,  4'd6,  1'b0, 4'd11, 3'b001},
    {4'd15, 4'd1,  1'b0, 4'd0,  3'b100},
    {4'd7,  4'd2,  1'b1, 4'd5,  3'b100},
    {4'd2,  4'd7,  1'b1, 4'd5,  3'b010},
    {4'd8,  4'd1,  1'b1, 4'd7,  3'b101},
    {4'd6,  4'd6,  1'b1, 4'd0,  3'b100},
    {4'd0,  4'd15, 1'b1, 4'd15, 3'b010}
  };

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic ts);
    @(negedge clk);
    a = ta; b = tb; sub = ts;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    a = '0; b = '0; sub = 1'b0;
    a5 = '0; b5 = '0; sub5 = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // idle state: zero operands, add mode
    apply('0, '0, 1'b0);
    check("R1 idle res", res, 0);
    check("R1 idle carry", c, 0);
    check("R5 idle neg", n, 0);
    check("R4 idle ovf", v, 0);

    // vector table
    for (int k = 0; k < 9; k++) begin
      apply(VEC[k][15:12], VEC[k][11:8], VEC[k][7]);
      check(VEC[k][7] ? "R2/R3 table res" : "R1 table res", res, int'(VEC[k][6:3]));
      check("R1/R2/R3 table carry", c, int'(VEC[k][2]));
      check("R3/R5 table neg", n, int'(VEC[k][1]));
      check("R4 table ovf", v, int'(VEC[k][0]));
    end

    // exhaustive sweep against integer arithmetic
    for (int m = 0; m < 2; m++) begin
      for (int x = 0; x < (1 << W); x++) begin
        for (int y = 0; y < (1 << W); y++) begin
          int sx, sy, sr, full, e_res, e_c, e_n, e_v;
          sx = (x >= (1 << (W-1))) ? x - (1 << W) : x;
          sy = (y >= (1 << (W-1))) ? y - (1 << W) : y;
          if (m == 0) begin
            full  = x + y;
            e_res = full % (1 << W);
            e_c   = full >> W;
            e_n   = 0;
            sr    = sx + sy;
          end else begin
            e_c   = (x >= y) ? 1 : 0;
            e_res = (x >= y) ? x - y : y - x;
            e_n   = (x < y) ? 1 : 0;
            sr    = sx - sy;
          end
          e_v = (sr > (1 << (W-1)) - 1 || sr < -(1 << (W-1))) ? 1 : 0;
          apply(W'(x), W'(y), m[0]);
          if (m == 0) begin
            check("R1 sweep res", res, e_res);
            check("R1 sweep carry", c, e_c);
            check("R5 sweep neg", n, e_n);
          end else if (x >= y) begin
            check("R2 sweep res", res, e_res);
            check("R2 sweep carry", c, e_c);
            check("R2 sweep neg", n, e_n);
          end else begin
            check("R3 sweep res", res, e_res);
            check("R3 sweep carry", c, e_c);
            check("R3 sweep neg", n, e_n);
          end
          check("R4 sweep ovf", v, e_v);
          if (res == '0) check("R6 zero not negative", n, 0);
        end
      end
    end

    // 5-bit instance: 19 - 30
    @(negedge clk);
    a5 = 5'd19; b5 = 5'd30; sub5 = 1'b1;
    #(CLK_PERIOD/4);
    check("R7 w5 res", res5, 11);
    check("R7 w5 neg", n5, 1);
    check("R7 w5 carry", c5, 0);
    check("R7 w5 ovf", v5, 0);
    @(negedge clk);
    a5 = 5'd30; b5 = 5'd19; sub5 = 1'b1;
    #(CLK_PERIOD/4);
    check("R7 w5 reverse res", res5, 11);
    check("R7 w5 reverse neg", n5, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule